// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block keeps track of a fixed set of page frames and decides, for every page reference that arrives, whether the page is already resident. Each frame holds a resident page tag, an occupied flag and a used bit. A circular pointer marks the frame that is considered next for replacement. A reference that matches a resident page is a hit. A hit sets that frame's used bit and leaves the pointer where it is.

On a miss the block runs a second-chance (clock) search from the pointer. If a frame has its used bit set, the search clears the bit and moves on to the next frame. The first frame found with a clear used bit receives the new page, and the pointer moves one frame past it. Empty frames always have clear used bits, so after reset they are filled in pointer order. The search can take several cycles. During that time the request side is held off.

References arrive on a valid/ready handshake. Each one produces a single-cycle result pulse. The pulse carries the hit flag, the frame that was hit or filled, and the page that was displaced, if any. Moving page contents is left to the surrounding system.

Top module: `clock_repl_sel`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and all frames are empty. The first NUM_FRAMES distinct pages are placed in frames 0, 1, 2 ... in order, each reported as a miss with `rsp_evict_valid` = 0.
- R2: A reference to a resident page gives `rsp_hit` = 1, with `rsp_frame` equal to the index of the frame holding it and `rsp_evict_valid` = 0. The result pulse comes in the cycle after acceptance, and the pointer does not move.
- R3: A hit sets the used bit of its frame. Placing a page in a frame leaves that frame's used bit clear.
- R4: On a miss, each frame reached by the pointer with its used bit set has the bit cleared and is skipped. Each skip adds exactly one cycle, so the result arrives 1 + (number of skips) cycles after acceptance.
- R5: On a miss, the first frame reached with a clear used bit receives the new page (`rsp_hit` = 0, `rsp_frame` = that index), and the pointer moves forward by one. If the frame was occupied, `rsp_evict_valid` = 1 and `rsp_evict_page` is its old page. Otherwise `rsp_evict_valid` = 0 and `rsp_evict_page` = 0.
- R6: The pointer wraps from frame NUM_FRAMES-1 to frame 0. `rsp_frame` is always below NUM_FRAMES.
- R7: `req_ready` is 0 while a search is in progress, and at most NUM_FRAMES consecutive cycles. Every accepted reference produces exactly one `rsp_valid` pulse, one cycle long.
- R8: With 3 frames, the reference string 2,3,2,4,6,2,5,6,1,4,6 applied from reset gives exactly 4 hits among the 11 references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A page reference is offered |
| req_ready | output | 1 | Block can accept a reference (no search running) |
| req_page | input | PAGE_W | Page number of the reference |
| rsp_valid | output | 1 | One-cycle pulse: result fields are valid |
| rsp_hit | output | 1 | 1 = page was resident, 0 = page was placed |
| rsp_frame | output | PTR_W | Frame that was hit or filled |
| rsp_evict_valid | output | 1 | 1 = an occupied frame was overwritten |
| rsp_evict_page | output | PAGE_W | Page that was displaced (0 when none) |

## Verification
A stuck or lost used bit shows up at the ports as a wrong hit/miss decision, a wrong victim frame or a wrong displaced page, usually within a few references. A wrong used bit also changes the number of cycles a miss takes, because every skip costs one cycle. So the bench checks the latency of every response as well as its fields. A pointer that wraps wrongly or moves on a hit gives a wrong `rsp_frame` on the very next miss.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic int unsigned ptr_width(input int unsigned frames);
        return (frames > 1) ? $clog2(frames) : 1;
    endfunction

endpackage

// File: rtl/clock_tag_match.sv
module clock_tag_match #(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned PAGE_W     = 8,
    localparam int unsigned PTR_W     = clock_repl_pkg::ptr_width(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] tags,
    input  logic [NUM_FRAMES-1:0]             occupied,
    input  logic [PAGE_W-1:0]                 page,
    output logic                              hit,
    output logic [PTR_W-1:0]                  hit_idx
);

    logic [NUM_FRAMES-1:0] match;

    // one comparator per frame, all in parallel
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        assign match[g] = occupied[g] && (tags[g] == page);
    end

    // at most one frame can hold a given page, so OR-encoding is exact
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (match[i]) begin
                hit_idx = hit_idx | PTR_W'(i);
            end
        end
        hit = |match;
    end

endmodule

// File: rtl/clock_ptr_step.sv
module clock_ptr_step #(
    parameter int unsigned NUM_FRAMES = 4,
    localparam int unsigned PTR_W     = clock_repl_pkg::ptr_width(NUM_FRAMES)
) (
    input  logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_next
);

    localparam bit POW2 = (NUM_FRAMES > 1) && ((NUM_FRAMES & (NUM_FRAMES - 1)) == 0);

    if (NUM_FRAMES == 1) begin : g_single
        assign ptr_next = '0;
    end else if (POW2) begin : g_pow2
        // natural overflow of the counter gives the wrap
        assign ptr_next = ptr + 1'b1;
    end else begin : g_cmp
        assign ptr_next = (ptr == PTR_W'(NUM_FRAMES - 1)) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/clock_repl_sel.sv
module clock_repl_sel #(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned PAGE_W     = 8,
    localparam int unsigned PTR_W     = clock_repl_pkg::ptr_width(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PTR_W-1:0]  rsp_frame,
    output logic              rsp_evict_valid,
    output logic [PAGE_W-1:0] rsp_evict_page
);

    import clock_repl_pkg::*;

    typedef struct packed {
        scan_state_e                        state;
        logic [NUM_FRAMES-1:0][PAGE_W-1:0]  tags;
        logic [NUM_FRAMES-1:0]              occupied;
        logic [NUM_FRAMES-1:0]              used;
        logic [PTR_W-1:0]                   ptr;
        logic [PAGE_W-1:0]                  pend_page;
        logic                               rsp_valid;
        logic                               rsp_hit;
        logic [PTR_W-1:0]                   rsp_frame;
        logic                               rsp_evict_valid;
        logic [PAGE_W-1:0]                  rsp_evict_page;
    } sel_state_t;

    sel_state_t s_d, s_q;

    logic             lk_hit;
    logic [PTR_W-1:0] lk_idx;
    logic [PTR_W-1:0] ptr_next;
    logic [PAGE_W-1:0] cand_page;
    logic             search_step;

    clock_tag_match #(
        .NUM_FRAMES (NUM_FRAMES),
        .PAGE_W     (PAGE_W)
    ) i_match (
        .tags     (s_q.tags),
        .occupied (s_q.occupied),
        .page     (req_page),
        .hit      (lk_hit),
        .hit_idx  (lk_idx)
    );

    clock_ptr_step #(
        .NUM_FRAMES (NUM_FRAMES)
    ) i_step (
        .ptr      (s_q.ptr),
        .ptr_next (ptr_next)
    );

    // page being placed: fresh reference in idle, held page while searching
    assign cand_page = (s_q.state == ST_IDLE) ? req_page : s_q.pend_page;

    // a search step happens on an idle miss or on every scanning cycle
    assign search_step = ((s_q.state == ST_IDLE) && req_valid && !lk_hit)
                       || (s_q.state == ST_SCAN);

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;

        if ((s_q.state == ST_IDLE) && req_valid && lk_hit) begin
            // resident: mark used, pointer stays
            s_d.used[lk_idx]    = 1'b1;
            s_d.rsp_valid       = 1'b1;
            s_d.rsp_hit         = 1'b1;
            s_d.rsp_frame       = lk_idx;
            s_d.rsp_evict_valid = 1'b0;
            s_d.rsp_evict_page  = '0;
        end

        if (search_step) begin
            s_d.pend_page = cand_page;
            if (s_q.used[s_q.ptr]) begin
                // second chance: clear and move on
                s_d.used[s_q.ptr] = 1'b0;
                s_d.ptr           = ptr_next;
                s_d.state         = ST_SCAN;
            end else begin
                // victim found: place page with used bit clear
                s_d.rsp_valid       = 1'b1;
                s_d.rsp_hit         = 1'b0;
                s_d.rsp_frame       = s_q.ptr;
                s_d.rsp_evict_valid = s_q.occupied[s_q.ptr];
                s_d.rsp_evict_page  = s_q.occupied[s_q.ptr] ? s_q.tags[s_q.ptr] : '0;
                s_d.tags[s_q.ptr]     = cand_page;
                s_d.occupied[s_q.ptr] = 1'b1;
                s_d.used[s_q.ptr]     = 1'b0;
                s_d.ptr               = ptr_next;
                s_d.state             = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{
                state:           ST_IDLE,
                tags:            '0,
                occupied:        '0,
                used:            '0,
                ptr:             '0,
                pend_page:       '0,
                rsp_valid:       1'b0,
                rsp_hit:         1'b0,
                rsp_frame:       '0,
                rsp_evict_valid: 1'b0,
                rsp_evict_page:  '0
            };
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready       = (s_q.state == ST_IDLE);
    assign rsp_valid       = s_q.rsp_valid;
    assign rsp_hit         = s_q.rsp_hit;
    assign rsp_frame       = s_q.rsp_frame;
    assign rsp_evict_valid = s_q.rsp_evict_valid;
    assign rsp_evict_page  = s_q.rsp_evict_page;

endmodule

// File: rtl/clock_repl_chk.sv
module clock_repl_chk #(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned PAGE_W     = 8,
    localparam int unsigned PTR_W     = clock_repl_pkg::ptr_width(NUM_FRAMES),
    localparam int unsigned CNT_W     = $clog2(NUM_FRAMES + 2) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PAGE_W-1:0] req_page,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PTR_W-1:0]  rsp_frame,
    input logic              rsp_evict_valid,
    input logic [PAGE_W-1:0] rsp_evict_page
);

    logic [CNT_W-1:0] busy_cnt_q;

    // consecutive cycles with ready low, counted before the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (req_ready) begin
            busy_cnt_q <= '0;
        end else begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
        end
    end

    AST_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || !req_ready)) else $error("accept without progress"); // R7

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready))) else $error("unprompted response"); // R7

    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (busy_cnt_q < CNT_W'(NUM_FRAMES))) else $error("search too long"); // R4

    AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_evict_valid) else $error("hit reports eviction"); // R2

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_ready)) else $error("hit after search"); // R2

    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_frame < PTR_W'(NUM_FRAMES))) else $error("frame out of range"); // R6

    AST_NO_EVICT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_evict_valid) |-> (rsp_evict_page == '0)) else $error("stray evict page"); // R5

endmodule

bind clock_repl_sel clock_repl_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .PAGE_W     (PAGE_W)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_page        (req_page),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_frame       (rsp_frame),
    .rsp_evict_valid (rsp_evict_valid),
    .rsp_evict_page  (rsp_evict_page)
);

// File: tb/test_clock_repl_sel.sv
module test_clock_repl_sel;

    localparam int CLK_PERIOD = 10;
    localparam int FR         = 3;
    localparam int PW         = 8;
    localparam int PTRW       = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [PW-1:0]   req_page = '0;
    logic            rsp_valid;
    logic            rsp_hit;
    logic [PTRW-1:0] rsp_frame;
    logic            rsp_evict_valid;
    logic [PW-1:0]   rsp_evict_page;

    int n_tests = 0;
    int n_fail  = 0;

    // bench reference state
    int  m_tag [FR];
    bit  m_occ [FR];
    bit  m_used[FR];
    int  m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    clock_repl_sel #(.NUM_FRAMES(FR), .PAGE_W(PW)) i_clock_repl_sel (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_page        (req_page),
        .rsp_valid       (rsp_valid),
        .rsp_hit         (rsp_hit),
        .rsp_frame       (rsp_frame),
        .rsp_evict_valid (rsp_evict_valid),
        .rsp_evict_page  (rsp_evict_page)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < FR; i++) begin
            m_tag[i] = 0; m_occ[i] = 0; m_used[i] = 0;
        end
        m_ptr = 0;
    endfunction

    // second-chance policy as stated in the requirements
    function automatic void model_ref(input int page, output bit hit, output int frame,
                                      output bit ev, output int evp, output int skips);
        hit = 0; frame = 0; ev = 0; evp = 0; skips = 0;
        for (int i = 0; i < FR; i++) begin
            if (m_occ[i] && m_tag[i] == page) begin
                hit = 1; frame = i;
            end
        end
        if (hit) begin
            m_used[frame] = 1;
            return;
        end
        while (m_used[m_ptr]) begin
            m_used[m_ptr] = 0;
            m_ptr = (m_ptr + 1) % FR;
            skips++;
        end
        frame = m_ptr;
        ev  = m_occ[m_ptr];
        evp = m_occ[m_ptr] ? m_tag[m_ptr] : 0;
        m_tag[m_ptr] = page; m_occ[m_ptr] = 1; m_used[m_ptr] = 0;
        m_ptr = (m_ptr + 1) % FR;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    endtask

    // one reference, full check; returns observed hit
    task automatic issue(input int page, output bit got_hit);
        bit e_hit, e_ev; int e_fr, e_evp, e_sk, lat;
        model_ref(page, e_hit, e_fr, e_ev, e_evp, e_sk);
        @(negedge clk);
        req_valid = 1'b1;
        req_page  = PW'(page);
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) check("R7 ready low while searching", 1, 0);
            @(posedge clk); #1;
            lat++;
        end
        got_hit = rsp_hit;
        check("R3/R4 latency 1+skips", lat, 1 + e_sk);
        check("R2 hit flag", int'(rsp_hit), int'(e_hit));
        check("R5/R6 frame index", int'(rsp_frame), e_fr);
        check("R5 evict flag", int'(rsp_evict_valid), int'(e_ev));
        check("R5 evict page", int'(rsp_evict_page), e_evp);
        @(posedge clk); #1;
        check("R7 single-cycle pulse", int'(rsp_valid), 0);
        check("R7 ready after response", int'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seq[11] = '{2, 3, 2, 4, 6, 2, 5, 6, 1, 4, 6};
        int hits;
        bit h;
        void'($urandom(32'd20240607));

        do_reset();

        // R1: first distinct pages fill frames in order, no eviction
        // the string below also drives R3 (used bits), R4 (skips) and R6 (wrap)
        hits = 0;
        foreach (seq[i]) begin
            issue(seq[i], h);
            if (h) hits++;
        end
        check("R8 hit count of reference string", hits, 4);

        // directed: repeated hits, then a miss that must clear every used bit
        do_reset();
        for (int i = 0; i < FR; i++) issue(10 + i, h);
        for (int i = 0; i < FR; i++) issue(10 + i, h);
        issue(99, h);   // R4: full lap of skips before replacing frame 0
        issue(11, h);   // R2: still resident after the lap

        // constrained random mix over a small page range to get many hits
        do_reset();
        for (int n = 0; n < 300; n++) begin
            issue(int'($urandom_range(5, 0)), h);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule